// File: doc/BRIEF.md
# Boot Stream Width-Detecting Word Packer

This block fetches a boot image from an external memory whose data width is not known in advance. It may be 8, 16 or 32 bits wide. After a start pulse, it issues one read at a time, beginning at a base address. The low byte of the first location read tells the block how wide the memory is. Every later read is treated as one piece of a 32-bit word, and the block collects as many pieces as that width needs before it offers the word on a valid/ready output stream.

Pieces are packed least significant part first. The width code itself is consumed and never appears on the output. A word-count input sets how many 32-bit words follow the code. When the last of them has been taken, the block raises a done flag and goes idle. An unknown code raises an error flag and stops all further reads until the next start.

Top module: `boot_width_packer`

## Requirements
- R1: The width is decoded from bits 7:0 of the first location read only. Value 8'h08 selects 8-bit pieces, 8'h10 selects 16-bit pieces and 8'h20 selects 32-bit pieces. Bits 31:8 of that location have no influence.
- R2: In 8-bit mode, four reads make one word. The earliest read lands in out_data[7:0], then [15:8], then [23:16], and the latest lands in [31:24].
- R3: In 16-bit mode, two reads make one word. The earlier read lands in out_data[15:0] and the later one in out_data[31:16].
- R4: In 32-bit mode, each read becomes one output word unchanged.
- R5: Narrow modes use only rd_rdata[7:0] (8-bit mode) or rd_rdata[15:0] (16-bit mode). The remaining data lines do not affect out_data.
- R6: The location holding the width code is not output. The first word is built from the second location onward, and out_valid stays low until every piece of a word has arrived.
- R7: If the low byte of the first read is none of the three codes, err rises and done stays low. No further rd_req is issued until start is pulsed again.
- R8: The first rd_addr equals base_addr. Each later request uses the previous address plus one, wrapping at 2^ADDR_W, whatever the width.
- R9: While out_valid is high and out_ready is low, out_data and out_valid hold steady and rd_req stays low.
- R10: Exactly word_count words are delivered. done rises in the cycle after the last word is accepted, and no more reads follow. With word_count of zero, done rises right after the code is read and no word is output.
- R11: A synchronous reset, even mid-transfer, forces rd_req, out_valid, done and err low and forgets the selected width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a load when the block is idle |
| base_addr | input | ADDR_W | Address of the location holding the width code |
| word_count | input | CNT_W | Number of 32-bit words to deliver after the code |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Address of the current read |
| rd_rvalid | input | 1 | Read data is present this cycle |
| rd_rdata | input | 32 | Read data |
| out_valid | output | 1 | out_data holds a complete word |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Assembled word |
| done | output | 1 | All words delivered; held until the next start |
| err | output | 1 | Unknown width code; held until the next start |

## Verification
The bench builds the block with ADDR_W = 10 and CNT_W = 6, so that a 1024-entry memory model covers the whole address space. With these values, loads placed near the top of memory make rd_addr wrap past zero in the middle of a word. Counts up to 63 keep long 8-bit loads short enough for many randomized runs. Response latency and consumer stalls are both randomized. As a result, partially assembled words and held output words occur under every width, alongside directed cases for bad codes, a zero count and a reset taken mid-load.

// File: rtl/bwp_pkg.sv
package bwp_pkg;

  typedef enum logic [1:0] {
    WID_NONE = 2'd0,
    WID_8    = 2'd1,
    WID_16   = 2'd2,
    WID_32   = 2'd3
  } wid_e;

  localparam logic [7:0] CODE_W8  = 8'h08;
  localparam logic [7:0] CODE_W16 = 8'h10;
  localparam logic [7:0] CODE_W32 = 8'h20;

  // Map the low byte of the first location to a piece width.
  function automatic wid_e decode_code(input logic [7:0] code);
    wid_e w;
    case (code)
      CODE_W8:  w = WID_8;
      CODE_W16: w = WID_16;
      CODE_W32: w = WID_32;
      default:  w = WID_NONE;
    endcase
    return w;
  endfunction

  // Index of the final piece of a word for a given width.
  function automatic logic [1:0] last_index(input wid_e w);
    logic [1:0] n;
    case (w)
      WID_8:   n = 2'd3;
      WID_16:  n = 2'd1;
      default: n = 2'd0;
    endcase
    return n;
  endfunction

  // Drop one piece into its lane of the partial word.
  function automatic logic [31:0] merge_piece(input logic [31:0] acc,
                                              input wid_e        w,
                                              input logic [1:0]  idx,
                                              input logic [31:0] d);
    logic [31:0] r;
    r = acc;
    case (w)
      WID_8:   r[{idx, 3'b000} +: 8]     = d[7:0];
      WID_16:  r[{idx[0], 4'b0000} +: 16] = d[15:0];
      WID_32:  r = d;
      default: r = acc;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bwp_addr_gen.sv
module bwp_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= base;
    end else if (step) begin
      addr <= addr + 1'b1;
    end
  end

  // R8: every accepted response moves the read pointer by one location
  p_addr_step_r8: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (addr == $past(addr) + 1'b1));

  // R8: a new load starts at the base address
  p_addr_load_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr == $past(base)));

endmodule

// File: rtl/bwp_assembler.sv
module bwp_assembler
  import bwp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        hdr_load,
  input  logic        piece_load,
  input  logic [31:0] rdata,
  output logic        hdr_ok,
  output logic        last_piece,
  output logic [31:0] word,
  output wid_e        width
);

  wid_e       code_wid;
  logic [1:0] piece_idx;
  logic [1:0] piece_lim;

  assign code_wid   = decode_code(rdata[7:0]);
  assign hdr_ok     = (code_wid != WID_NONE);
  assign piece_lim  = last_index(width);
  assign last_piece = (piece_idx == piece_lim);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      width     <= WID_NONE;
      piece_idx <= '0;
      word      <= '0;
    end else if (hdr_load) begin
      if (hdr_ok) begin
        width <= code_wid;
      end
    end else if (piece_load) begin
      word      <= merge_piece(word, width, piece_idx, rdata);
      piece_idx <= last_piece ? 2'd0 : piece_idx + 2'd1;
    end
  end

  // R2/R3: the piece index never passes the last lane of the chosen width
  p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
    piece_idx <= piece_lim);

  // R1: the width changes only when a code is read or a load restarts
  p_width_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!hdr_load && !clear) |=> $stable(width));

  // R6: pieces are only collected once a width is known
  p_piece_needs_width_r6: assert property (@(posedge clk) disable iff (rst)
    piece_load |-> (width != WID_NONE));

endmodule

// File: rtl/bwp_ctrl.sv
module bwp_ctrl #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] word_count,
  input  logic             rvalid,
  input  logic             hdr_ok,
  input  logic             last_piece,
  input  logic             out_ready,
  output logic             rd_req,
  output logic             out_valid,
  output logic             done,
  output logic             err,
  output logic             load_go,
  output logic             hdr_accept,
  output logic             piece_accept
);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_SEND} st_e;

  st_e              state;
  logic             is_hdr;
  logic [CNT_W-1:0] words_left;
  logic             resp;
  logic             handoff;
  logic             final_word;

  assign rd_req       = (state == ST_REQ);
  assign out_valid    = (state == ST_SEND);
  assign load_go      = (state == ST_IDLE) && start;
  assign resp         = (state == ST_WAIT) && rvalid;
  assign hdr_accept   = resp && is_hdr;
  assign piece_accept = resp && !is_hdr;
  assign handoff      = out_valid && out_ready;
  assign final_word   = (words_left == {{(CNT_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      is_hdr     <= 1'b0;
      words_left <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            is_hdr     <= 1'b1;
            words_left <= word_count;
            done       <= 1'b0;
            err        <= 1'b0;
            state      <= ST_REQ;
          end
        end
        ST_REQ: state <= ST_WAIT;
        ST_WAIT: begin
          if (rvalid) begin
            if (is_hdr) begin
              is_hdr <= 1'b0;
              if (!hdr_ok) begin
                err   <= 1'b1;
                state <= ST_IDLE;
              end else if (words_left == '0) begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end else begin
                state <= ST_REQ;
              end
            end else begin
              state <= last_piece ? ST_SEND : ST_REQ;
            end
          end
        end
        ST_SEND: begin
          if (out_ready) begin
            words_left <= words_left - 1'b1;
            if (final_word) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_REQ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: after a bad code no read goes out until a new start
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (err && !start) |=> !rd_req);

  // R7/R10: the two end flags never coexist
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  // R9: a stalled word keeps being offered
  p_valid_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  // R10: accepting the final word ends the load
  p_last_done_r10: assert property (@(posedge clk) disable iff (rst)
    (handoff && final_word) |=> (done && !rd_req && !out_valid));

endmodule

// File: rtl/boot_width_packer.sv
module boot_width_packer
  import bwp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  word_count,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rvalid,
  input  logic [31:0]       rd_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic              done,
  output logic              err
);

  logic load_go;
  logic hdr_accept;
  logic piece_accept;
  logic hdr_ok;
  logic last_piece;
  logic addr_step;
  wid_e width;

  assign addr_step = hdr_accept || piece_accept;

  bwp_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .word_count   (word_count),
    .rvalid       (rd_rvalid),
    .hdr_ok       (hdr_ok),
    .last_piece   (last_piece),
    .out_ready    (out_ready),
    .rd_req       (rd_req),
    .out_valid    (out_valid),
    .done         (done),
    .err          (err),
    .load_go      (load_go),
    .hdr_accept   (hdr_accept),
    .piece_accept (piece_accept)
  );

  bwp_addr_gen #(.ADDR_W(ADDR_W)) addr_i (
    .clk  (clk),
    .rst  (rst),
    .load (load_go),
    .base (base_addr),
    .step (addr_step),
    .addr (rd_addr)
  );

  bwp_assembler asm_i (
    .clk        (clk),
    .rst        (rst),
    .clear      (load_go),
    .hdr_load   (hdr_accept),
    .piece_load (piece_accept),
    .rdata      (rd_rdata),
    .hdr_ok     (hdr_ok),
    .last_piece (last_piece),
    .word       (out_data),
    .width      (width)
  );

  // R9: the offered word does not change while it waits
  p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data));

  // R9: no read is issued while a word is being offered
  p_no_read_in_send_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !rd_req);

  // R6: a word is only offered once a width has been chosen
  p_valid_needs_width_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (width != WID_NONE));

endmodule

// File: tb/boot_width_packer_tb_top.sv
`timescale 1ns/1ps
module boot_width_packer_tb_top;

  localparam int AW   = 10;
  localparam int CW   = 6;
  localparam int MEMN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] word_count = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_rvalid = 1'b0;
  logic [31:0]   rd_rdata = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [31:0]   out_data;
  logic          done;
  logic          err;

  always #10 clk = ~clk;

  boot_width_packer #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .word_count(word_count), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .done(done), .err(err)
  );

  logic [31:0] mem [MEMN];
  int checks = 0;
  int fails  = 0;
  int reqs   = 0;
  int words  = 0;
  int cur_base = 0;
  int cur_bytes = 1;
  int ready_mode = 0;
  logic run_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int wrap(input int a);
    return a & (MEMN - 1);
  endfunction

  // Expected k-th word: built by concatenation from the model memory.
  function automatic logic [31:0] exp_word(input int base, input int nbytes,
                                           input int k);
    int a;
    a = base + 1 + k * (4 / nbytes);
    if (nbytes == 1)
      return {mem[wrap(a+3)][7:0], mem[wrap(a+2)][7:0],
              mem[wrap(a+1)][7:0], mem[wrap(a)][7:0]};
    else if (nbytes == 2)
      return {mem[wrap(a+1)][15:0], mem[wrap(a)][15:0]};
    else
      return mem[wrap(a)];
  endfunction

  // Memory responder: one outstanding read, latency 1 to 3 cycles.
  initial begin
    bit pend = 0;
    int cnt = 0;
    int a = 0;
    forever begin
      @(negedge clk);
      rd_rvalid = 1'b0;
      if (rst) begin
        pend = 0;
      end else begin
        if (pend) begin
          if (cnt == 0) begin
            rd_rvalid = 1'b1;
            rd_rdata  = mem[a];
            pend = 0;
          end else begin
            cnt--;
          end
        end
        if (rd_req) begin
          if (run_on)
            chk(rd_addr == AW'(cur_base + reqs), "R8 read address",
                32'(rd_addr), 32'(wrap(cur_base + reqs)));
          chk(!out_valid, "R9 read while offering", 32'(out_valid), 32'd0);
          reqs++;
          pend = 1;
          a = int'(rd_addr);
          cnt = int'($urandom_range(2, 0));
        end
      end
    end
  end

  // Output sink with random back-pressure and hold checking.
  initial begin
    bit stalled = 0;
    logic [31:0] held = '0;
    forever begin
      @(negedge clk);
      if (stalled) begin
        chk(out_valid === 1'b1, "R9 valid dropped while stalled", 32'(out_valid), 32'd1);
        chk(out_data === held, "R9 data changed while stalled", out_data, held);
      end
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom_range(1, 0) == 1);
        default: out_ready = ($urandom_range(3, 0) == 0);
      endcase
      #1;
      stalled = 0;
      if (!rst && out_valid) begin
        if (out_ready) begin
          chk(out_data === exp_word(cur_base, cur_bytes, words),
              (cur_bytes == 1) ? "R2 R5 R6 byte packing" :
              (cur_bytes == 2) ? "R3 R5 R6 half packing" : "R4 passthrough",
              out_data, exp_word(cur_base, cur_bytes, words));
          words++;
        end else begin
          stalled = 1;
          held = out_data;
        end
      end
    end
  end

  task automatic fill_mem(input int base, input logic [7:0] code);
    for (int i = 0; i < MEMN; i++) mem[i] = $urandom;
    mem[base] = {mem[base][31:8], code};
  endtask

  task automatic pulse_start(input int base, input int count);
    @(negedge clk);
    base_addr  = AW'(base);
    word_count = CW'(count);
    cur_base   = base;
    reqs  = 0;
    words = 0;
    run_on = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end;
    int n = 0;
    while (!done && !err && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 20000, "R10 load never ended", 32'(n), 32'd0);
  endtask

  task automatic run_good(input int base, input int nbytes, input int count,
                          input int rmode);
    fill_mem(base, 8'(nbytes * 8));
    cur_bytes  = nbytes;
    ready_mode = rmode;
    pulse_start(base, count);
    wait_end();
    repeat (3) @(negedge clk);
    chk(done === 1'b1 && err === 1'b0, "R10 done flag", {30'd0, done, err}, 32'd2);
    chk(words == count, "R10 word total", 32'(words), 32'(count));
    chk(reqs == 1 + count * (4 / nbytes), "R8 R10 read total",
        32'(reqs), 32'(1 + count * (4 / nbytes)));
    run_on = 1'b0;
  endtask

  task automatic run_bad(input int base, input logic [31:0] hdr);
    fill_mem(base, 8'h00);
    mem[base] = hdr;
    ready_mode = 0;
    pulse_start(base, 5);
    wait_end();
    repeat (20) @(negedge clk);
    chk(err === 1'b1 && done === 1'b0, "R7 err flag", {30'd0, done, err}, 32'd1);
    chk(reqs == 1, "R7 R1 reads after bad code", 32'(reqs), 32'd1);
    chk(words == 0, "R7 words after bad code", 32'(words), 32'd0);
    run_on = 1'b0;
  endtask

  initial begin
    int wd = 0;
    while (wd < 190000) begin
      @(posedge clk);
      wd++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEMN; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk({rd_req, out_valid, done, err} === 4'b0, "R11 reset outputs",
        {28'd0, rd_req, out_valid, done, err}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // directed: each width, always ready
    run_good(16, 1, 4, 0);
    run_good(100, 2, 3, 0);
    run_good(200, 4, 5, 0);
    // back-pressure
    run_good(300, 1, 6, 2);
    run_good(400, 2, 7, 1);
    // zero count: done right after the code
    run_good(500, 2, 0, 0);
    // address wrap inside a word
    run_good(1020, 1, 3, 1);
    // bad codes; code in upper bits only must not count (R1)
    run_bad(40, 32'h0000_0018);
    run_bad(60, 32'h0820_1000);
    // recovery after an error
    run_good(80, 4, 2, 1);

    // reset in the middle of a load (R11)
    fill_mem(600, 8'h08);
    cur_bytes = 1;
    ready_mode = 2;
    pulse_start(600, 20);
    repeat (25) @(negedge clk);
    rst = 1'b1;
    run_on = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({rd_req, out_valid, done, err} === 4'b0, "R11 mid-load reset",
        {28'd0, rd_req, out_valid, done, err}, 32'd0);
    rst = 1'b0;
    run_good(700, 2, 4, 0);

    // random loads
    for (int t = 0; t < 14; t++) begin
      int nb;
      case ($urandom_range(2, 0))
        0: nb = 1;
        1: nb = 2;
        default: nb = 4;
      endcase
      run_good(int'($urandom_range(MEMN - 1, 0)), nb,
               int'($urandom_range(20, 1)), int'($urandom_range(2, 0)));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule